// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This block gathers the per-channel completion and fault events of a multi-channel DMA engine into one interrupt line and a small register window. Every channel owns a raw terminal-count flag and a raw error flag, each set by a one-cycle pulse from that channel's engine. The masks are not written by software. They are read straight from two bits of each channel's configuration word, which arrives on a flattened input bus, so the interrupt follows the configuration as soon as it changes.

Software sees the flags through a 32-bit register port with a byte address. There are raw views, masked views per event type, a combined masked view, a write-one-to-clear register per event type and a vector of enabled channels. A global configuration register and a synchronisation register are also held here, and eight identification words sit at the top of the 4 KiB window. Reads return data one cycle after the access. Any access to an address outside the map returns zero and raises a one-cycle error strobe.

Top module: `dma_irq_unit`

## Requirements
- R1: Channel c's terminal-count mask is bit 15 of its configuration word (`chanConf[c*32+15]`) and its error mask is bit 14. `irq` is high, with no register delay, whenever some channel has a raw terminal-count flag and that mask, or a raw error flag and that mask. After reset all flags are clear and `irq` is low.
- R2: Byte address 0x000 reads the OR of the masked terminal-count and masked error vectors. 0x004 reads the masked terminal-count vector and 0x00C reads the masked error vector. Bit c of each view belongs to channel c.
- R3: Byte address 0x014 reads the raw terminal-count flags and 0x018 reads the raw error flags, whatever the masks are.
- R4: A write to 0x008 clears each terminal-count flag whose bit is 1 in the write data. A write to 0x010 does the same for error flags. Flags at 0 bits keep their value. Both addresses read as zero.
- R5: A pulse on `tcSet[c]` or `errSet[c]` sets that flag at the next clock edge, and the flag then holds until it is cleared. When a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R6: Byte address 0x01C reads a vector whose bit c is bit 0 (the enable) of channel c's configuration word.
- R7: Byte addresses 0xFE0, 0xFE4 and so on up to 0xFFC read one identification byte each, in this order: 0x80 for an eight-channel build (0x81 for any other channel count), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. Writes to these addresses are ignored.
- R8: Byte address 0x030 is a read/write global configuration register that keeps bits [2:0], with the upper bits reading zero. Its bit 0 drives `ctlEnable`. Byte address 0x034 is a read/write synchronisation register that keeps bits [SYNC_W-1:0] (16 by default).
- R9: Every status bit at or above `NUM_CH` reads as zero.
- R10: A misaligned address, a word at 0x020 to 0x02C, or a word from 0x038 to 0xFDC is unmapped. A read there returns zero. Any access there, read or write, pulses `regErr` for one cycle in the cycle after the access and changes no state.
- R11: Read data appears on `regRdata` in the cycle after the read access and shows the state from before that access's clock edge. `regRdata` is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 1 | Register access valid this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte address within the window |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after the access |
| regErr | output | 1 | One-cycle strobe for an unmapped access |
| tcSet | input | NUM_CH | Per-channel terminal-count set pulses |
| errSet | input | NUM_CH | Per-channel error set pulses |
| chanConf | input | NUM_CH*32 | Channel configuration words, channel c in bits [c*32+31:c*32] |
| irq | output | 1 | Level interrupt |
| ctlEnable | output | 1 | Controller enable bit of the global configuration |

## Verification
Each result has its own due cycle. `irq` is combinational, so it is due in the same cycle as a configuration change and right after the edge that registers a set pulse. Read data and `regErr` are due one edge after the access. Flag changes from a pulse or a clear are visible to a read issued after that edge. The bench drives every input on a falling edge and samples at the next falling edge, which is half a period after the single register stage. Read results are therefore taken where they are due, and the idle-zero check is taken one cycle later.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  typedef enum logic [3:0] {
    RD_ZERO, RD_COMB, RD_MTC, RD_MERR, RD_RTC, RD_RERR,
    RD_ENA, RD_GCFG, RD_SYNC, RD_ID
  } rdSel_t;

  typedef struct packed {
    logic   clrTc;
    logic   clrErr;
    logic   wrGcfg;
    logic   wrSync;
    logic   rdEn;
    logic   bad;
    rdSel_t rdSel;
    logic [2:0] idIdx;
  } ctrlStrb_t;

  function automatic logic [7:0] idByte(input logic [2:0] idx, input int numCh);
    case (idx)
      3'd0: idByte = (numCh == 8) ? 8'h80 : 8'h81;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h0A;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrb_t         strb
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] ID_BASE = WORD_W'((1 << WORD_W) - 8);

  logic [WORD_W-1:0] wordIdx;
  logic aligned;
  logic isRd;
  logic isWr;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);
  assign isRd    = regSel && !regWrite;
  assign isWr    = regSel && regWrite;

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_ZERO;
    strb.rdEn   = isRd;
    strb.idIdx  = regAddr[4:2];
    if (regSel) begin
      if (!aligned) begin
        strb.bad = 1'b1;
      end else if (wordIdx >= ID_BASE) begin
        strb.rdSel = RD_ID;
      end else begin
        case (wordIdx)
          WORD_W'(0):  strb.rdSel = RD_COMB;
          WORD_W'(1):  strb.rdSel = RD_MTC;
          WORD_W'(2):  strb.clrTc = isWr;
          WORD_W'(3):  strb.rdSel = RD_MERR;
          WORD_W'(4):  strb.clrErr = isWr;
          WORD_W'(5):  strb.rdSel = RD_RTC;
          WORD_W'(6):  strb.rdSel = RD_RERR;
          WORD_W'(7):  strb.rdSel = RD_ENA;
          WORD_W'(12): begin strb.rdSel = RD_GCFG; strb.wrGcfg = isWr; end
          WORD_W'(13): begin strb.rdSel = RD_SYNC; strb.wrSync = isWr; end
          default:     strb.bad = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int GCFG_W = 3,
  parameter int SYNC_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [31:0]        regWdata,
  input  logic [NUM_CH-1:0]  tcSet,
  input  logic [NUM_CH-1:0]  errSet,
  input  logic [NUM_CH*32-1:0] chanConf,
  output logic [31:0]        regRdata,
  output logic               regErr,
  output logic               irq,
  output logic               ctlEnable
);
  localparam int CH_PAD   = 32 - NUM_CH;
  localparam int GCFG_PAD = 32 - GCFG_W;
  localparam int SYNC_PAD = 32 - SYNC_W;
  localparam int TC_BIT   = 15;
  localparam int ERR_BIT  = 14;

  logic [NUM_CH-1:0] tcRaw, errRaw;
  logic [NUM_CH-1:0] tcMask, errMask, enaVec;
  logic [NUM_CH-1:0] tcMsk, errMsk;
  logic [GCFG_W-1:0] gcfgQ;
  logic [SYNC_W-1:0] syncQ;
  logic [31:0]       rdMux;
  logic [NUM_CH-1:0] tcClr, errClr;

  for (genvar c = 0; c < NUM_CH; c++) begin : gMask
    assign tcMask[c]  = chanConf[c*32 + TC_BIT];
    assign errMask[c] = chanConf[c*32 + ERR_BIT];
    assign enaVec[c]  = chanConf[c*32];
  end

  assign tcMsk  = tcRaw & tcMask;
  assign errMsk = errRaw & errMask;
  assign irq    = |{tcMsk, errMsk};
  assign ctlEnable = gcfgQ[0];

  assign tcClr  = strb.clrTc  ? regWdata[NUM_CH-1:0] : '0;
  assign errClr = strb.clrErr ? regWdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcRaw  <= '0;
      errRaw <= '0;
    end else begin
      tcRaw  <= (tcRaw & ~tcClr) | tcSet;
      errRaw <= (errRaw & ~errClr) | errSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gcfgQ <= '0;
      syncQ <= '0;
    end else begin
      if (strb.wrGcfg) gcfgQ <= regWdata[GCFG_W-1:0];
      if (strb.wrSync) syncQ <= regWdata[SYNC_W-1:0];
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_COMB: rdMux = {{CH_PAD{1'b0}}, tcMsk | errMsk};
      RD_MTC:  rdMux = {{CH_PAD{1'b0}}, tcMsk};
      RD_MERR: rdMux = {{CH_PAD{1'b0}}, errMsk};
      RD_RTC:  rdMux = {{CH_PAD{1'b0}}, tcRaw};
      RD_RERR: rdMux = {{CH_PAD{1'b0}}, errRaw};
      RD_ENA:  rdMux = {{CH_PAD{1'b0}}, enaVec};
      RD_GCFG: rdMux = {{GCFG_PAD{1'b0}}, gcfgQ};
      RD_SYNC: rdMux = {{SYNC_PAD{1'b0}}, syncQ};
      RD_ID:   rdMux = {24'h0, idByte(strb.idIdx, NUM_CH)};
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata <= '0;
      regErr   <= 1'b0;
    end else begin
      regRdata <= strb.rdEn ? rdMux : '0;
      regErr   <= strb.bad;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|tcSet) |=> ((tcRaw & $past(tcSet)) == $past(tcSet))); // R5

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrTc |=> ((tcRaw & $past(regWdata[NUM_CH-1:0] & ~tcSet)) == '0)); // R4

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clrErr && errSet == '0) |=> $stable(errRaw)); // R5

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((|tcRaw) || (|errRaw))); // R1

  AST_BAD_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    strb.bad |=> regErr); // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> (regRdata == '0)); // R11

endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12,
  parameter int GCFG_W = 3,
  parameter int SYNC_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regSel,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  output logic                 regErr,
  input  logic [NUM_CH-1:0]    tcSet,
  input  logic [NUM_CH-1:0]    errSet,
  input  logic [NUM_CH*32-1:0] chanConf,
  output logic                 irq,
  output logic                 ctlEnable
);
  ctrlStrb_t strb;

  dma_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regSel   (regSel),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strb     (strb)
  );

  dma_irq_datapath #(
    .NUM_CH (NUM_CH),
    .GCFG_W (GCFG_W),
    .SYNC_W (SYNC_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWdata  (regWdata),
    .tcSet     (tcSet),
    .errSet    (errSet),
    .chanConf  (chanConf),
    .regRdata  (regRdata),
    .regErr    (regErr),
    .irq       (irq),
    .ctlEnable (ctlEnable)
  );

endmodule

// File: tb/dma_irq_unit_tb_top.sv
module dma_irq_unit_tb_top;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic regErr, irq, ctlEnable;
  logic [NCH-1:0] tcSet = '0, errSet = '0;
  logic [NCH*32-1:0] chanConf = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] expTc = '0, expErr = '0;
  logic [7:0] mTc, mErr, ena;

  always #5 clk = ~clk;

  dma_irq_unit #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regErr(regErr), .tcSet(tcSet), .errSet(errSet),
    .chanConf(chanConf), .irq(irq), .ctlEnable(ctlEnable)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = 1; regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 0; regWrite = 0;
  endtask

  task automatic doRead(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    regSel = 1; regWrite = 0; regAddr = a;
    @(negedge clk);
    d = regRdata; e = regErr;
    regSel = 0;
  endtask

  task automatic setConf(input logic [7:0] t, input logic [7:0] r, input logic [7:0] en);
    for (int c = 0; c < NCH; c++)
      chanConf[c*32 +: 32] = 32'h0001_2002 | (32'(t[c]) << 15) | (32'(r[c]) << 14) | 32'(en[c]);
  endtask

  task automatic pulse(input logic [7:0] t, input logic [7:0] r);
    @(negedge clk);
    tcSet = t; errSet = r;
    @(negedge clk);
    tcSet = '0; errSet = '0;
    expTc |= t; expErr |= r;
  endtask

  function automatic logic [7:0] idExp(input int i);
    logic [7:0] tbl [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return tbl[i];
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    logic [11:0] badAddr [8] = '{12'h020, 12'h024, 12'h028, 12'h02C, 12'h038, 12'h100, 12'hFDC, 12'h001};
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    check("R1 reset irq", 32'(irq), 0);
    doRead(12'h014, d, e); check("R3 reset raw tc", d, 0);
    doRead(12'h018, d, e); check("R3 reset raw err", d, 0);
    check("R10 reset no err", 32'(e), 0);
    doRead(12'h030, d, e); check("R8 reset gcfg", d, 0);

    // R11 idle cycle after a read returns zero
    @(negedge clk); check("R11 idle zero", regRdata, 0);

    // R7 identification bytes
    for (int i = 0; i < 8; i++) begin
      doWrite(12'hFE0 + 12'(i*4), 32'hFF);
      doRead(12'hFE0 + 12'(i*4), d, e);
      check($sformatf("R7 id %0d", i), d, 32'(idExp(i)));
    end

    // R8 global config and sync
    doWrite(12'h030, 32'hFFFF_FFFF);
    check("R8 ctlEnable high", 32'(ctlEnable), 1);
    doRead(12'h030, d, e); check("R8 gcfg width", d, 32'h7);
    doWrite(12'h034, 32'hFFFF_FFFF);
    doRead(12'h034, d, e); check("R8 sync width", d, 32'hFFFF);
    doWrite(12'h030, 32'h2);
    check("R8 ctlEnable low", 32'(ctlEnable), 0);

    // R10 unmapped sweep
    for (int i = 0; i < 8; i++) begin
      doRead(badAddr[i], d, e);
      check($sformatf("R10 read zero %h", badAddr[i]), d, 0);
      check($sformatf("R10 err strobe %h", badAddr[i]), 32'(e), 1);
      @(negedge clk); check("R10 strobe one cycle", 32'(regErr), 0);
    end
    doWrite(12'h031, 32'h5);
    check("R10 write strobe", 32'(regErr), 1);
    doRead(12'h030, d, e); check("R10 misaligned write ignored", d, 32'h2);

    // main sweep: R1 R2 R3 R4 R5 R6 R9
    for (int p = 0; p < 24; p++) begin
      logic [7:0] tp, rp, clrT, clrE;
      tp   = 8'(p * 73 + 29);
      rp   = 8'(p * 151 + 7);
      mTc  = 8'(p * 37 + 200);
      mErr = 8'(p * 91 + 3);
      ena  = 8'(p * 59 + 17);
      clrT = 8'(p * 113 + 66);
      clrE = 8'(p * 29 + 140);
      setConf(mTc, mErr, ena);
      pulse(tp, rp);
      check("R1 irq level", 32'(irq), 32'(|((expTc & mTc) | (expErr & mErr))));
      doRead(12'h014, d, e); check("R3 R9 raw tc", d, 32'(expTc));
      doRead(12'h018, d, e); check("R3 R9 raw err", d, 32'(expErr));
      doRead(12'h004, d, e); check("R2 R1 masked tc", d, 32'(expTc & mTc));
      doRead(12'h00C, d, e); check("R2 R1 masked err", d, 32'(expErr & mErr));
      doRead(12'h000, d, e); check("R2 combined", d, 32'((expTc & mTc) | (expErr & mErr)));
      doRead(12'h01C, d, e); check("R6 enable vector", d, 32'(ena));
      doRead(12'h008, d, e); check("R4 clear reg reads zero", d, 0);
      doWrite(12'h008, {24'hFFFFFF, clrT}); expTc &= ~clrT;
      doWrite(12'h010, {24'hFFFFFF, clrE}); expErr &= ~clrE;
      doRead(12'h014, d, e); check("R4 tc after clear", d, 32'(expTc));
      doRead(12'h018, d, e); check("R4 err after clear", d, 32'(expErr));
      // R1 irq follows mask change without delay
      setConf(8'hFF, 8'hFF, ena);
      #1 check("R1 irq all masks", 32'(irq), 32'(|(expTc | expErr)));
    end

    // R5 set beats a same-cycle clear
    pulse(8'hFF, 8'hFF);
    @(negedge clk);
    regSel = 1; regWrite = 1; regAddr = 12'h008; regWdata = 32'hFFFF_FFFF; tcSet = 8'h04;
    @(negedge clk);
    regSel = 0; regWrite = 0; tcSet = '0;
    doRead(12'h014, d, e); check("R5 set wins tc", d, 32'h04);
    @(negedge clk);
    regSel = 1; regWrite = 1; regAddr = 12'h010; regWdata = 32'hFFFF_FFFF; errSet = 8'h81;
    @(negedge clk);
    regSel = 0; regWrite = 0; errSet = '0;
    doRead(12'h018, d, e); check("R5 set wins err", d, 32'h81);
    doWrite(12'h008, 32'hFF); doWrite(12'h010, 32'hFF);
    check("R1 irq low after clear", 32'(irq), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule